// File: doc/BRIEF.md
# Configuration Transaction Channel Engine

This block is a small command engine that gives software indirect access to a bank of oscillator-clock setting words. Software places the value to send in a data-out register and then writes a command word. The command word names a device index and a function code, says whether the access is a read or a write, and carries a go bit. The go bit launches the access. It is never stored, so it always reads back as zero. Any reserved bits in the command are cleared when the word is stored.

Once launched, an access completes a fixed, parameter-set number of cycles later. On completion the engine sets a done flag. If the function or device code does not address an oscillator entry, it sets an error flag as well. A valid write moves the data-out value into the chosen entry. A valid read fills the data-return register from that entry. Each write to the command register clears the status flags. If a command write arrives while an access is still pending, the pending access is dropped and the new command takes over.

The bank holds a parameter number of entries, from 1 to 16, and each entry has its own reset value. The current value of every entry is driven out of the block so that clock-generation logic elsewhere can use it.

Top module: `ctc_engine`

## Requirements
- R1: After reset the registers read as follows: command 0x00100000, which is function code 1; status 0; data-out 0; data-return 0. Oscillator entry i equals bits [32*i+31:32*i] of the OSC_INIT parameter.
- R2: A write to the command register at byte offset 0xA8 stores the written value ANDed with 0x43F00FFF. That mask keeps the device field [11:0], the function field [25:20] and the write flag [30]. The go bit [31] always reads back as 0.
- R3: Every write to the command register clears the status word (offset 0xAC) to 0 on the next clock edge, whether or not the go bit is set. In the status word, bit 0 is done, bit 1 is error, and all other bits read as 0.
- R4: A command write with bit 31 set launches an access. Status stays 0 for the first LAT cycles after the write edge. Done becomes 1 on the edge LAT+1 cycles after the write edge. A command write with bit 31 clear launches nothing.
- R5: An access is valid only if the function field equals 1 and the device field is less than N_OSC. An invalid access completes with status 0x3, meaning error and done.
- R6: A valid write access (bit 30 = 1) copies into the selected entry the value that the data-out register holds on the completion edge. No other entry changes.
- R7: A valid read access (bit 30 = 0) loads the data-return register (offset 0xA0) with the selected entry. Failed reads and all write accesses leave the data-return register unchanged.
- R8: An invalid access changes no oscillator entry.
- R9: The data-out register (offset 0xA4) can be both read and written. Writes to the data-return and status offsets are ignored. Reads of any unmapped offset return 0.
- R10: A command write that arrives while an access is pending cancels that access, so the cancelled access changes no entry and sets no flag. The new command is then timed from its own write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte offset of the register for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, taken combinationally from bus_addr |
| osc_values | output | 32*N_OSC | Current value of every oscillator entry, with entry 0 in the lowest bits |

## Verification
The bench sweeps every combination of several function codes (0, 1, 2, 63), several device codes (0 to 3, 4, 7 and 0xFFF), and both directions. This separates the function check from the device bound check and catches off-by-one errors at N_OSC. It also confirms that reads fill only the data-return register and writes touch only the bank. Each launch checks status before and at the completion edge, so a latency off by one cycle is caught.

Directed cases cover the following:
- an all-ones command, to check masking;
- a command with only reserved bits set, to check the status clear without a launch;
- a command that cancels a pending write;
- a data-out update made after launch, to show that the value present at completion is the one used.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 12;

  // command word field placement
  localparam int DEV_LSB = 0;
  localparam int DEV_W   = 12;
  localparam int FN_LSB  = 20;
  localparam int FN_W    = 6;
  localparam int WR_BIT  = 30;
  localparam int GO_BIT  = 31;

  localparam logic [WORD_W-1:0] CMD_KEEP  = 32'h43F0_0FFF;
  localparam logic [WORD_W-1:0] CMD_RESET = 32'h0010_0000;
  localparam logic [FN_W-1:0]   FN_OSC    = 6'd1;

  localparam logic [ADDR_W-1:0] OFS_RTN  = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h0AC;

  typedef struct packed {
    logic err;
    logic done;
  } stat_t;
endpackage

// File: rtl/ctc_seq.sv
module ctc_seq
  import ctc_pkg::*;
#(
  parameter int N_OSC = 4,
  parameter int LAT   = 2,
  localparam int IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1,
  localparam int CNT_W = (LAT > 0) ? $clog2(LAT + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_go,
  input  logic [WORD_W-1:0] cmd_q,
  output logic              busy,
  output stat_t             stat,
  output logic              bank_we,
  output logic              rtn_le,
  output logic [IDX_W-1:0]  sel
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  stat_t            stat_q, stat_d;

  logic [DEV_W-1:0] dev;
  logic [FN_W-1:0]  fn;
  logic             is_wr, valid, finish;

  assign dev    = cmd_q[DEV_LSB +: DEV_W];
  assign fn     = cmd_q[FN_LSB +: FN_W];
  assign is_wr  = cmd_q[WR_BIT];
  assign valid  = (fn == FN_OSC) && (dev < DEV_W'(N_OSC));
  assign finish = busy_q && (cnt_q == '0) && !cmd_wr;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    stat_d = stat_q;
    if (cmd_wr) begin
      stat_d = '0;
      busy_d = cmd_go;
      cnt_d  = CNT_W'(LAT);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d      = 1'b0;
        stat_d.done = 1'b1;
        stat_d.err  = !valid;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      stat_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
    end
  end

  assign busy    = busy_q;
  assign stat    = stat_q;
  assign bank_we = finish && valid && is_wr;
  assign rtn_le  = finish && valid && !is_wr;
  assign sel     = dev[IDX_W-1:0];
endmodule

// File: rtl/ctc_osc_bank.sv
module ctc_osc_bank
  import ctc_pkg::*;
#(
  parameter int N_OSC = 4,
  parameter logic [N_OSC*WORD_W-1:0] OSC_INIT = '0,
  localparam int IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        sel,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORD_W-1:0]       rdata,
  output logic [N_OSC*WORD_W-1:0] flat
);
  logic [WORD_W-1:0] ent [N_OSC];

  for (genvar g = 0; g < N_OSC; g++) begin : g_ent
    logic hit;
    assign hit = we && (sel == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[g] <= OSC_INIT[g*WORD_W +: WORD_W];
      end else if (hit) begin
        ent[g] <= wdata;
      end
    end
    assign flat[g*WORD_W +: WORD_W] = ent[g];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_OSC; i++) begin
      if (sel == IDX_W'(i)) rdata = ent[i];
    end
  end
endmodule

// File: rtl/ctc_regs.sv
module ctc_regs
  import ctc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  stat_t             stat,
  input  logic              rtn_le,
  input  logic [WORD_W-1:0] osc_rd,
  output logic              cmd_wr,
  output logic              cmd_go,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] dout_q,
  output logic [WORD_W-1:0] rtn_q,
  output logic [WORD_W-1:0] rd_data
);
  logic dout_wr;

  assign cmd_wr  = bus_we && (bus_addr == OFS_CMD);
  assign cmd_go  = cmd_wr && bus_wdata[GO_BIT];
  assign dout_wr = bus_we && (bus_addr == OFS_DOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_RESET;
    end else if (cmd_wr) begin
      cmd_q <= bus_wdata & CMD_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_wr) begin
      dout_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtn_q <= '0;
    end else if (rtn_le) begin
      rtn_q <= osc_rd;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_RTN:  rd_data = rtn_q;
      OFS_DOUT: rd_data = dout_q;
      OFS_CMD:  rd_data = cmd_q;
      OFS_STAT: rd_data = {{(WORD_W-2){1'b0}}, stat};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ctc_engine.sv
module ctc_engine
  import ctc_pkg::*;
#(
  parameter int N_OSC = 4,
  parameter int LAT   = 2,
  parameter logic [N_OSC*32-1:0] OSC_INIT =
    128'h0BEB_C200_017D_7840_02FA_F080_05F5_E100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [N_OSC*32-1:0] osc_values
);
  localparam int IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              cmd_wr, cmd_go, busy, bank_we, rtn_le;
  logic [WORD_W-1:0] cmd_q, dout_q, rtn_q, osc_rd;
  logic [IDX_W-1:0]  sel;
  stat_t             stat;

  ctc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat      (stat),
    .rtn_le    (rtn_le),
    .osc_rd    (osc_rd),
    .cmd_wr    (cmd_wr),
    .cmd_go    (cmd_go),
    .cmd_q     (cmd_q),
    .dout_q    (dout_q),
    .rtn_q     (rtn_q),
    .rd_data   (bus_rdata)
  );

  ctc_seq #(.N_OSC(N_OSC), .LAT(LAT)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_wr  (cmd_wr),
    .cmd_go  (cmd_go),
    .cmd_q   (cmd_q),
    .busy    (busy),
    .stat    (stat),
    .bank_we (bank_we),
    .rtn_le  (rtn_le),
    .sel     (sel)
  );

  ctc_osc_bank #(.N_OSC(N_OSC), .OSC_INIT(OSC_INIT)) u_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (bank_we),
    .sel   (sel),
    .wdata (dout_q),
    .rdata (osc_rd),
    .flat  (osc_values)
  );
endmodule

// File: rtl/ctc_engine_chk.sv
module ctc_engine_chk #(
  parameter int N_OSC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [11:0]         bus_addr,
  input logic [31:0]         bus_wdata,
  input logic                busy,
  input logic [1:0]          stat,
  input logic [31:0]         rtn_q,
  input logic [N_OSC*32-1:0] osc_values
);
  logic cmd_write;
  assign cmd_write = bus_we && (bus_addr == 12'h0A8);

  // R3: any command write leaves a cleared status
  a_r3_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write |=> (stat == 2'b00));

  // R4: a go write puts the engine into the pending state
  a_r4_pending_on_go: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && bus_wdata[31]) |=> busy);

  // R4: done appears only as a pending access ends
  a_r4_done_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(busy));

  // R5: error is only ever reported with done
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] |-> stat[0]);

  // R7: data-return holds while nothing is pending
  a_r7_rtn_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rtn_q));

  // R6: the bank holds while nothing is pending
  a_r6_bank_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(osc_values));
endmodule

bind ctc_engine ctc_engine_chk #(.N_OSC(N_OSC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .busy       (busy),
  .stat       (stat),
  .rtn_q      (rtn_q),
  .osc_values (osc_values)
);

// File: tb/ctc_engine_tb.sv
module ctc_engine_tb;
  localparam int N   = 4;
  localparam int LAT = 2;
  localparam logic [N*32-1:0] INIT = 128'h1111_0003_2222_0002_3333_0001_4444_0000;
  localparam logic [11:0] A_RTN = 12'h0A0, A_DOUT = 12'h0A4, A_CMD = 12'h0A8, A_STAT = 12'h0AC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N*32-1:0] osc_values;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] model [N];
  logic [31:0] rtn_m;

  always #5 clk = ~clk;

  ctc_engine #(.N_OSC(N), .LAT(LAT), .OSC_INIT(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_values(osc_values)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < N; i++) check(tag, osc_values[i*32 +: 32], model[i]);
  endtask

  function automatic logic [31:0] mk_cmd(input logic go, input logic w,
                                         input logic [5:0] fn, input logic [11:0] dev);
    return {go, w, 4'b0000, fn, 8'h00, dev};
  endfunction

  // launch one access and follow it to completion
  task automatic txn(input logic [5:0] fn, input logic [11:0] dev, input logic w,
                     input logic [31:0] dout);
    logic [31:0] v;
    logic ok;
    ok = (fn == 6'd1) && (dev < 12'(N));
    wr(A_DOUT, dout);
    wr(A_CMD, mk_cmd(1'b1, w, fn, dev));
    rd(A_STAT, v); check("R3 status after launch", v, 32'h0);
    for (int c = 0; c < LAT; c++) begin
      @(negedge clk); rd(A_STAT, v); check("R4 status while pending", v, 32'h0);
    end
    @(negedge clk);
    rd(A_STAT, v);
    check(ok ? "R4 done on time" : "R5 error on bad code", v, ok ? 32'h1 : 32'h3);
    if (ok && w) model[dev[1:0]] = dout;
    if (ok && !w) rtn_m = model[dev[1:0]];
    rd(A_RTN, v); check("R7 data-return", v, rtn_m);
    check_bank(ok ? "R6 bank after write" : "R8 bank after bad access");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R4 act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int k;
    for (int i = 0; i < N; i++) model[i] = INIT[i*32 +: 32];
    rtn_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CMD, v);  check("R1 command reset", v, 32'h0010_0000);
    rd(A_STAT, v); check("R1 status reset", v, 32'h0);
    rd(A_DOUT, v); check("R1 data-out reset", v, 32'h0);
    rd(A_RTN, v);  check("R1 data-return reset", v, 32'h0);
    check_bank("R1 bank reset");

    // R9 register access rules
    wr(A_DOUT, 32'hDEAD_BEEF); rd(A_DOUT, v); check("R9 data-out readback", v, 32'hDEAD_BEEF);
    wr(A_RTN, 32'h1234_5678);  rd(A_RTN, v);  check("R9 data-return ignores write", v, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, v); check("R9 status ignores write", v, 32'h0);
    rd(12'h000, v); check("R9 unmapped reads zero", v, 32'h0);
    rd(12'h0B0, v); check("R9 unmapped reads zero", v, 32'h0);

    // sweep of function, device and direction
    k = 0;
    foreach (model[i]) begin end
    for (int fi = 0; fi < 4; fi++) begin
      for (int di = 0; di < 7; di++) begin
        for (int w = 1; w >= 0; w--) begin
          logic [5:0] fn;
          logic [11:0] dev;
          fn  = (fi == 0) ? 6'd0 : (fi == 1) ? 6'd1 : (fi == 2) ? 6'd2 : 6'd63;
          dev = (di < 5) ? 12'(di) : (di == 5) ? 12'd7 : 12'hFFF;
          txn(fn, dev, w[0], 32'h5A00_0000 + 32'(k) * 32'h0001_0003);
          k++;
        end
      end
    end

    // R2 masking with every bit set (launches an invalid access: fn 63)
    wr(A_CMD, 32'hFFFF_FFFF);
    rd(A_CMD, v); check("R2 stored mask, go reads 0", v, 32'h43F0_0FFF);
    repeat (LAT + 1) @(negedge clk);
    rd(A_STAT, v); check("R5 all-ones command errors", v, 32'h3);
    check_bank("R8 bank after all-ones command");

    // R3 status cleared by a command without go; nothing launches
    wr(A_CMD, 32'h3C0F_F000);
    rd(A_CMD, v);  check("R2 reserved bits dropped", v, 32'h0);
    rd(A_STAT, v); check("R3 status cleared without go", v, 32'h0);
    repeat (LAT + 3) @(negedge clk);
    rd(A_STAT, v); check("R4 no launch without go", v, 32'h0);
    check_bank("R4 bank unchanged without go");

    // R10 cancel a pending write with a read of another entry
    wr(A_DOUT, 32'hCAFE_0001);
    wr(A_CMD, mk_cmd(1'b1, 1'b1, 6'd1, 12'd0));
    wr(A_CMD, mk_cmd(1'b1, 1'b0, 6'd1, 12'd2));
    for (int c = 0; c < LAT; c++) begin
      @(negedge clk); rd(A_STAT, v); check("R10 retimed from new write", v, 32'h0);
    end
    @(negedge clk);
    rd(A_STAT, v); check("R10 new command done", v, 32'h1);
    rtn_m = model[2];
    rd(A_RTN, v); check("R10 read result", v, rtn_m);
    check_bank("R10 cancelled write left bank alone");

    // R6 data-out value at the completion edge is used
    wr(A_DOUT, 32'h0BAD_0BAD);
    wr(A_CMD, mk_cmd(1'b1, 1'b1, 6'd1, 12'd3));
    wr(A_DOUT, 32'h600D_600D);
    repeat (LAT) @(negedge clk);
    model[3] = 32'h600D_600D;
    rd(A_STAT, v); check("R6 late data-out write done", v, 32'h1);
    check_bank("R6 late data-out value stored");

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule